// File: doc/BRIEF.md
# Serial ADC output formatter

This block turns parallel capture words from a stereo converter pair (two 16-bit channels) and one 12-bit auxiliary converter into serial data. It runs on a fast system clock. It samples an external bit clock and an external frame clock, and it launches one data bit on each falling edge of the bit clock. A receiver then samples that bit on the next rising edge. A frame begins on the bit-clock fall at which the frame clock is first seen high. Each data word is sent MSB first from the start of its slot.

Two layouts are available. In the two-line layout, line 1 sends the left word in the first half of the frame and the right word in the second half. Line 2 sends the padded auxiliary word in both halves, with the same alignment. In the one-line layout, line 1 sends four back-to-back 16-bit slots (left, right, aux, aux) and line 2 stays low. A combined mode behaves like the two-line layout on the outputs. The frame length is 32, 48 or 64 bit clocks. The one-line layout needs 64; with a shorter frame the slots that do not fit are lost and an error flag is raised.

Top module: `adc_serial_fmt`

## Requirements
- R1: After reset, and until the first frame starts, `sd1_o`, `sd2_o` and `err_o` are low.
- R2: A frame starts on the bit-clock fall where `fs_i` is high and was low at the previous fall. Both data lines change only after a bit-clock fall and hold steady for the rest of that bit period.
- R3: With `layout_i` = 0, bit k of `sd1_o` (k = 0 at frame start) is left word bit 15-k for k < 16, right word bit 15-(k-N/2) for N/2 <= k < N/2+16, and 0 otherwise. N is the frame length.
- R4: The auxiliary word is sent as a 16-bit value: `aux_i` sits in bits 15:4 and bits 3:0 are zero.
- R5: With `layout_i` = 0, `sd2_o` sends the padded auxiliary word at the same positions as the left and right words on `sd1_o`.
- R6: With `layout_i` = 1, `sd1_o` bit k is bit 15-(k mod 16) of slot k/16, where the slots are left, right, padded aux, padded aux. `sd2_o` stays 0.
- R7: `layout_i` = 2 (combined) and 3 produce the same outputs as `layout_i` = 0.
- R8: The data words, `layout_i` and `ratio_i` are captured at frame start. Changes later in the frame do not affect that frame.
- R9: `ratio_i` selects the frame length: 0 gives 32, 1 gives 48, and 2 or 3 give 64. With `layout_i` = 1 and a frame shorter than 64, slots past the frame end are not sent. For that frame `err_o` is high. It is low for every other captured configuration.
- R10: Bit periods at or beyond the frame length drive 0 on both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Bit clock |
| fs_i | input | 1 | Frame clock, high for the first half of the frame |
| left_i | input | 16 | Left converter word |
| right_i | input | 16 | Right converter word |
| aux_i | input | 12 | Auxiliary converter word |
| layout_i | input | 2 | 0 two-line, 1 one-line, 2 combined, 3 as two-line |
| ratio_i | input | 2 | Bit clocks per frame: 0=32, 1=48, 2/3=64 |
| sd1_o | output | 1 | Serial data line 1 |
| sd2_o | output | 1 | Serial data line 2 |
| err_o | output | 1 | One-line layout with a frame shorter than 64 |

## Verification
The sweep covers every layout code against every ratio code, with six word sets:
- a walking pattern with MSB and LSB set (8001/7FFE), which exposes bit-order and slot-offset errors;
- all-ones against all-zeros, which shows which slot lands in which position and where zero fill begins;
- a mixed nibble pattern, which separates left from right and aux slots;
- two random sets.

In every frame, the next frame's words and configuration are applied a few bits after frame start. This exposes any design that reads its inputs live instead of capturing them. Each bit is sampled both while the bit clock is low and while it is high, to confirm the data holds for the whole period. A trailing idle stretch with no new frame then checks the zero fill after the frame end.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    LAYOUT_DUAL   = 2'd0,
    LAYOUT_SINGLE = 2'd1,
    LAYOUT_COMBO  = 2'd2,
    LAYOUT_RSVD   = 2'd3
  } layout_e;
endpackage

// File: rtl/fmt_frame_timer.sv
module fmt_frame_timer #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(4 * WORD_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             fs_i,
  output logic             fall_o,
  output logic             start_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(4 * WORD_W);

  logic sck_q1, sck_q2, fs_q1, fs_last;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q1 <= 1'b0;
      sck_q2 <= 1'b0;
      fs_q1  <= 1'b0;
    end else begin
      sck_q1 <= sck_i;
      sck_q2 <= sck_q1;
      fs_q1  <= fs_i;
    end
  end

  assign fall_o  = sck_q2 & ~sck_q1;
  assign start_o = fall_o & fs_q1 & ~fs_last;

  always_comb begin
    if (start_o)               cnt_nxt_o = '0;
    else if (cnt_q == CNT_MAX) cnt_nxt_o = CNT_MAX;
    else                       cnt_nxt_o = cnt_q + 1'b1;
  end

  // counter parks at CNT_MAX so an idle line stays silent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_last <= 1'b0;
      cnt_q   <= CNT_MAX;
    end else if (fall_o) begin
      fs_last <= fs_q1;
      cnt_q   <= cnt_nxt_o;
    end
  end

  AST_START_RESTARTS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> cnt_q == '0); // R2
endmodule

// File: rtl/fmt_word_capture.sv
module fmt_word_capture
  import adc_fmt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AUX_W  = 12,
  parameter int CNT_W  = $clog2(4 * WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic [AUX_W-1:0]  aux_i,
  input  logic [1:0]        layout_i,
  input  logic [1:0]        ratio_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic [WORD_W-1:0] aux_o,
  output layout_e           layout_o,
  output logic [CNT_W-1:0]  flen_o
);
  localparam int PAD_W = WORD_W - AUX_W;

  function automatic logic [CNT_W-1:0] frame_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(2 * WORD_W);
      2'd1:    return CNT_W'(3 * WORD_W);
      default: return CNT_W'(4 * WORD_W);
    endcase
  endfunction

  logic [WORD_W-1:0] left_q, right_q, aux_q;
  layout_e           layout_q;
  logic [CNT_W-1:0]  flen_q;
  logic [WORD_W-1:0] aux_pad;

  assign aux_pad = {aux_i, {PAD_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q   <= '0;
      right_q  <= '0;
      aux_q    <= '0;
      layout_q <= LAYOUT_DUAL;
      flen_q   <= CNT_W'(4 * WORD_W);
    end else if (start_i) begin
      left_q   <= left_i;
      right_q  <= right_i;
      aux_q    <= aux_pad;
      layout_q <= layout_e'(layout_i);
      flen_q   <= frame_len(ratio_i);
    end
  end

  // at frame start the first bit must come from the fresh words
  assign left_o   = start_i ? left_i                : left_q;
  assign right_o  = start_i ? right_i               : right_q;
  assign aux_o    = start_i ? aux_pad               : aux_q;
  assign layout_o = start_i ? layout_e'(layout_i)   : layout_q;
  assign flen_o   = start_i ? frame_len(ratio_i)    : flen_q;

  AST_HELD_WORDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(left_q) && $stable(right_q) && $stable(aux_q)); // R8
endmodule

// File: rtl/fmt_bit_select.sv
module fmt_bit_select
  import adc_fmt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AUX_W  = 12,
  parameter int CNT_W  = $clog2(4 * WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic [WORD_W-1:0] aux_i,
  input  layout_e           layout_i,
  input  logic [CNT_W-1:0]  flen_i,
  output logic              sd1_o,
  output logic              sd2_o
);
  localparam int POS_W = $clog2(WORD_W);
  localparam logic [POS_W-1:0] TOP_BIT = POS_W'(WORD_W - 1);

  logic              single, in_frame, in_right, dual_valid;
  logic [CNT_W-1:0]  half, dpos;
  logic [POS_W-1:0]  didx, sidx;
  logic [1:0]        slot;
  logic [WORD_W-1:0] dword, sword;
  logic              d1, d2, s1;
  logic              sd1_q, sd2_q;

  assign single   = (layout_i == LAYOUT_SINGLE);
  assign in_frame = cnt_i < flen_i;
  assign half     = flen_i >> 1;

  // two-line: each half holds one word, zero fill after it
  assign in_right   = cnt_i >= half;
  assign dpos       = in_right ? cnt_i - half : cnt_i;
  assign dual_valid = in_frame && (dpos < CNT_W'(WORD_W));
  assign didx       = TOP_BIT - dpos[POS_W-1:0];
  assign dword      = in_right ? right_i : left_i;
  assign d1         = dual_valid & dword[didx];
  assign d2         = dual_valid & aux_i[didx];

  // one-line: four packed slots, anything past the frame end is dropped
  assign slot = cnt_i[POS_W+1:POS_W];
  assign sidx = TOP_BIT - cnt_i[POS_W-1:0];
  always_comb begin
    case (slot)
      2'd0:    sword = left_i;
      2'd1:    sword = right_i;
      default: sword = aux_i;
    endcase
  end
  assign s1 = in_frame & sword[sidx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd1_q <= 1'b0;
      sd2_q <= 1'b0;
    end else if (fall_i) begin
      sd1_q <= single ? s1 : d1;
      sd2_q <= single ? 1'b0 : d2;
    end
  end

  assign sd1_o = sd1_q;
  assign sd2_o = sd2_q;

  AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sd1_q) && $stable(sd2_q)); // R2
  AST_AUX_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && !single && dual_valid && (dpos[POS_W-1:0] >= POS_W'(AUX_W)) |=> !sd2_q); // R4
  AST_DROP_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && !in_frame |=> !sd1_q && !sd2_q); // R10
endmodule

// File: rtl/adc_serial_fmt.sv
module adc_serial_fmt
  import adc_fmt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AUX_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              fs_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic [AUX_W-1:0]  aux_i,
  input  logic [1:0]        layout_i,
  input  logic [1:0]        ratio_i,
  output logic              sd1_o,
  output logic              sd2_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(4 * WORD_W) + 1;
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(4 * WORD_W);

  logic              fall, start;
  logic [CNT_W-1:0]  cnt_nxt, flen;
  logic [WORD_W-1:0] left_w, right_w, aux_w;
  layout_e           layout;
  logic              err_q;

  fmt_frame_timer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .sck_i, .fs_i,
    .fall_o(fall), .start_o(start), .cnt_nxt_o(cnt_nxt)
  );

  fmt_word_capture #(.WORD_W(WORD_W), .AUX_W(AUX_W), .CNT_W(CNT_W)) i_capture (
    .clk_i, .rst_ni, .start_i(start),
    .left_i, .right_i, .aux_i, .layout_i, .ratio_i,
    .left_o(left_w), .right_o(right_w), .aux_o(aux_w),
    .layout_o(layout), .flen_o(flen)
  );

  fmt_bit_select #(.WORD_W(WORD_W), .AUX_W(AUX_W), .CNT_W(CNT_W)) i_select (
    .clk_i, .rst_ni, .fall_i(fall), .cnt_i(cnt_nxt),
    .left_i(left_w), .right_i(right_w), .aux_i(aux_w),
    .layout_i(layout), .flen_i(flen),
    .sd1_o, .sd2_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (start) err_q <= (layout == LAYOUT_SINGLE) && (flen < FULL_LEN);
  end
  assign err_o = err_q;

  AST_ERR_ONLY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start |-> layout == LAYOUT_SINGLE && flen < FULL_LEN); // R9
  AST_SD2_QUIET_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall && layout == LAYOUT_SINGLE |=> !sd2_o); // R6
endmodule

// File: tb/test_adc_serial_fmt.sv
module test_adc_serial_fmt;
  logic        clk = 1'b0, rst_ni = 1'b0, sck = 1'b1, fs = 1'b0;
  logic [15:0] left_d = '0, right_d = '0;
  logic [11:0] aux_d = '0;
  logic [1:0]  layout_d = '0, ratio_d = '0;
  logic        sd1, sd2, err;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_serial_fmt i_adc_serial_fmt (
    .clk_i(clk), .rst_ni, .sck_i(sck), .fs_i(fs),
    .left_i(left_d), .right_i(right_d), .aux_i(aux_d),
    .layout_i(layout_d), .ratio_i(ratio_d),
    .sd1_o(sd1), .sd2_o(sd2), .err_o(err)
  );

  task automatic check(input string req, input logic act, input logic exp, input int f, input int k);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s frame %0d bit %0d: actual %b expected %b", req, f, k, act, exp);
    end
  endtask

  function automatic int flen_of(input int rs);
    return rs == 0 ? 32 : (rs == 1 ? 48 : 64);
  endfunction

  // expected bit from the requirements (R3..R7, R9, R10)
  function automatic logic exp_bit(input int line, input int lay, input int n, input int k,
                                   input logic [15:0] l, input logic [15:0] r, input logic [11:0] a);
    logic [15:0] ap, w;
    int pos;
    ap = {a, 4'b0000};
    if (k >= n) return 1'b0;
    if (lay == 1) begin
      if (line == 2) return 1'b0;
      w = (k / 16 == 0) ? l : ((k / 16 == 1) ? r : ap);
      return w[15 - (k % 16)];
    end
    if (k < n / 2) begin pos = k; w = l; end
    else begin pos = k - n / 2; w = r; end
    if (pos >= 16) return 1'b0;
    if (line == 2) w = ap;
    return w[15 - pos];
  endfunction

  function automatic string tag_of(input int line, input int lay, input int n, input int k);
    int pos;
    pos = (k < n / 2) ? k : k - n / 2;
    if (k >= 4 && k < 8) return "R8";
    if (lay == 1) return (line == 1 && n < 64) ? "R9" : "R6";
    if (lay >= 2) return "R7";
    if (line == 2) return (pos >= 12 && pos < 16) ? "R4" : "R5";
    return "R3";
  endfunction

  task automatic plan(input int f, output logic [15:0] l, output logic [15:0] r,
                      output logic [11:0] a, output int lay, output int rs);
    int p;
    lay = f % 4;
    rs  = (f / 4) % 4;
    p   = f / 16;
    case (p)
      0: begin l = 16'h8001; r = 16'h7FFE; a = 12'hFFF; end
      1: begin l = 16'hFFFF; r = 16'h0000; a = 12'h800; end
      2: begin l = 16'hA5C3; r = 16'h3C5A; a = 12'h5A5; end
      3: begin l = 16'h0000; r = 16'hFFFF; a = 12'h001; end
      default: begin l = 16'($urandom); r = 16'($urandom); a = 12'($urandom); end
    endcase
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] cl, cr, nl, nr;
    logic [11:0] ca, na;
    int clay, crs, nlay, nrs, n;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", sd1, 1'b0, -1, 0);
    check("R1", sd2, 1'b0, -1, 0);
    check("R1", err, 1'b0, -1, 0);

    plan(0, cl, cr, ca, clay, crs);
    left_d = cl; right_d = cr; aux_d = ca; layout_d = 2'(clay); ratio_d = 2'(crs);
    for (int f = 0; f < 96; f++) begin
      n = flen_of(crs);
      plan(f + 1, nl, nr, na, nlay, nrs);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        sck = 1'b0;
        fs = (k < n / 2);
        if (k == 3) begin  // R8: next frame's inputs appear mid-frame
          left_d = nl; right_d = nr; aux_d = na; layout_d = 2'(nlay); ratio_d = 2'(nrs);
        end
        repeat (4) @(negedge clk);
        check(tag_of(1, clay, n, k), sd1, exp_bit(1, clay, n, k, cl, cr, ca), f, k);
        check(tag_of(2, clay, n, k), sd2, exp_bit(2, clay, n, k, cl, cr, ca), f, k);
        if (k == 5) check("R9", err, logic'(clay == 1 && n < 64), f, k);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        check("R2", sd1, exp_bit(1, clay, n, k, cl, cr, ca), f, k);
        check("R2", sd2, exp_bit(2, clay, n, k, cl, cr, ca), f, k);
        repeat (2) @(negedge clk);
      end
      cl = nl; cr = nr; ca = na; clay = nlay; crs = nrs;
    end

    // R10: no further frame start, lines stay low
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      sck = 1'b0;
      fs = 1'b0;
      repeat (4) @(negedge clk);
      check("R10", sd1, 1'b0, 96, k);
      check("R10", sd2, 1'b0, 96, k);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule